// File: doc/BRIEF.md
# Flash Command Front End with Sticky Status

This block models the command side of a parallel NOR-style flash part inside a synchronous design. Three active-low strobes (chip enable, write enable, output enable), an address bus and an 8-bit data path are oversampled by the system clock. A bus write occurs when chip enable and write enable are both low and output enable is high. The byte and address are captured from the last sample taken before the first of the two enables returns high.

Captured bytes are decoded as commands, or as program data when they follow a program-setup command. The block keeps the read mode (array contents, status byte or identifier codes) and a status byte with sticky error flags. It holds a small array where programming can only clear bits and erase sets a whole block to ones. A cycle counter stands in for the duration of the internal algorithm.

While status is being read, the driven byte is frozen. A newer status value appears only after the read strobes are released and asserted again. The data path is split into an input byte, an output byte and an output-enable flag, which a pad ring combines into one bidirectional bus.

Top module: `flash_cmd_if`

## Requirements
- R1: A bus write is taken only while chip enable and write enable are low and output enable is high. The address and byte taken are those present just before the first of chip enable or write enable rises, whichever enable rises first. A strobe made with output enable low has no effect.
- R2: Programming stores the old array byte ANDed with the written byte, so bits only go from 1 to 0.
- R3: A byte is programmed only when it is the write directly after command 40h or 10h and the program-voltage-valid input is high. With that input low, the array is unchanged and status bits 4 and 3 are set.
- R4: Status byte layout: bit 7 = ready (1 = idle), bit 6 = erase suspended, bit 5 = erase error, bit 4 = program error, bit 3 = low program voltage, bits 2..0 = 0. After a program or erase, and after a suspend, reads return this byte without a 70h command.
- R5: While a status read stays active, the driven byte does not change, even when the status changes. A release and re-assertion of output enable or chip enable shows the new value.
- R6: Command 70h selects status reads and FFh selects array reads. Command 90h selects identifier reads: address bit 0 = 0 returns MFR_ID (default A7h), and 1 returns DEV_ID (default 5Eh).
- R7: Status bits 5..3 are sticky. They clear only on command 50h or on assertion of the reset/power-down input.
- R8: Erase is 20h followed by D0h. The D0h write's address bits [ADDR_W-1 -: BLK_W] select the block filled with FFh, and other blocks keep their contents. Any other second byte erases nothing and sets status bits 5 and 4.
- R9: Ready reads 0 for exactly BUSY_CYC clock cycles of active operation after a program or erase starts.
- R10: dq_oe is 1 only when chip enable and output enable are low and write enable is high, as seen through the input synchronizer.
- R11: B0h during an active erase suspends it: status reads C0h with no errors. D0h resumes it, clearing bit 6 and driving ready low until the remaining cycles finish.
- R12: After the reset/power-down input is released, reads return array data, the status byte is 80h, and the array contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rp_n | input | 1 | Reset / power-down, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| vpp_ok | input | 1 | Program voltage valid |
| dq_in | input | 8 | Data / command byte from the bus |
| dq_out | output | 8 | Byte driven toward the bus |
| dq_oe | output | 1 | Drive enable for dq_out |

## Verification
Program writes are issued in both enable orderings, and the byte and address are changed in the gap between the two rising enables. A design that captures on the later edge therefore stores a different value at a different address. Programs are repeated onto already-written bytes to separate an AND from an overwrite. Erases are aimed at one block while another holds data, to show the block select works. Error cases (low program voltage, a bad erase confirm, a write with no setup) are followed by a successful operation, then by the clear command, and then by reset, which shows exactly what drops the sticky bits. One status read is held open across the end of an operation and then reopened, to tell a frozen output from a live one.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_READ_ID      = 8'h90;
    localparam logic [7:0] CMD_PGM_SETUP    = 8'h40;
    localparam logic [7:0] CMD_PGM_SETUP2   = 8'h10;
    localparam logic [7:0] CMD_ERS_SETUP    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_ID
    } rmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_ERS_SUSP
    } state_e;

    typedef struct packed {
        logic ers;
        logic pgm;
        logic vpp;
    } err_t;

    function automatic logic [7:0] pack_status(input logic ready, input logic susp, input err_t e);
        return {ready, susp, e.ers, e.pgm, e.vpp, 3'b000};
    endfunction

endpackage

// File: rtl/fcmd_bus_sync.sv
module fcmd_bus_sync #(
    parameter int ADDR_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rp_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              vpp_ok,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] w_addr,
    output logic [7:0]        w_data,
    output logic              w_vpp,
    output logic              rd_act,
    output logic [ADDR_W-1:0] cur_addr
);

    typedef struct packed {
        logic              ce_n;
        logic              we_n;
        logic              oe_n;
        logic              vpp;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } smp_t;

    localparam smp_t IDLE_SMP = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, vpp: 1'b0,
                                  addr: '0, data: '0};

    smp_t raw;
    smp_t stg_d [STAGES];
    smp_t stg_q [STAGES];
    smp_t prev_d, prev_q;
    smp_t cur;

    assign raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n, vpp: vpp_ok, addr: addr, data: din};
    assign cur = stg_q[STAGES-1];

    function automatic logic is_wr(input smp_t s);
        return !s.ce_n && !s.we_n && s.oe_n;
    endfunction

    always_comb begin
        stg_d[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        prev_d = cur;
    end

    always_ff @(posedge clk or negedge rp_n) begin
        if (!rp_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= IDLE_SMP;
            end
            prev_q <= IDLE_SMP;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
            prev_q <= prev_d;
        end
    end

    // the window closes on whichever enable rises first; take the last sample inside it
    assign wr_stb   = is_wr(prev_q) && !is_wr(cur);
    assign w_addr   = prev_q.addr;
    assign w_data   = prev_q.data;
    assign w_vpp    = prev_q.vpp;
    assign rd_act   = !cur.ce_n && !cur.oe_n && cur.we_n;
    assign cur_addr = cur.addr;

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              pgm_we,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [7:0]        pgm_data,
    input  logic              ers_we,
    input  logic [BLK_W-1:0]  ers_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int WORDS  = 1 << ADDR_W;
    localparam int BLK_SH = ADDR_W - BLK_W;

    logic [7:0] mem_d [WORDS];
    logic [7:0] mem_q [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
            if (pgm_we && (pgm_addr == ADDR_W'(i))) begin
                mem_d[i] = mem_q[i] & pgm_data;
            end
            if (ers_we && (ers_blk == BLK_W'(i >> BLK_SH))) begin
                mem_d[i] = 8'hFF;
            end
        end
    end

    // cell contents survive reset / power-down
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BLK_W    = 2,
    parameter int BUSY_CYC = 64
) (
    input  logic              clk,
    input  logic              rp_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [7:0]        w_data,
    input  logic              w_vpp,
    output logic              pgm_we,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [7:0]        pgm_data,
    output logic              ers_we,
    output logic [BLK_W-1:0]  ers_blk,
    output rmode_e            rmode,
    output logic [7:0]        status,
    output logic              op_start,
    output logic              clr_stb
);

    localparam int TMR_W = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(BUSY_CYC - 1);

    typedef struct packed {
        state_e           state;
        rmode_e           rmode;
        err_t             err;
        logic [TMR_W-1:0] timer;
    } ctl_t;

    localparam ctl_t CTL_RST = '{state: ST_IDLE, rmode: RM_ARRAY, err: '0, timer: '0};

    ctl_t ctl_d, ctl_q;
    logic busy;

    always_comb begin
        ctl_d    = ctl_q;
        pgm_we   = 1'b0;
        ers_we   = 1'b0;
        op_start = 1'b0;
        clr_stb  = 1'b0;
        pgm_addr = w_addr;
        pgm_data = w_data;
        ers_blk  = w_addr[ADDR_W-1 -: BLK_W];

        unique case (ctl_q.state)
            ST_PGM_BUSY, ST_ERS_BUSY: begin
                ctl_d.timer = ctl_q.timer - TMR_W'(1);
                if (ctl_q.timer == '0) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.timer = '0;
                end else if (wr_stb && (ctl_q.state == ST_ERS_BUSY) && (w_data == CMD_SUSPEND)) begin
                    ctl_d.state = ST_ERS_SUSP;
                    ctl_d.rmode = RM_STATUS;
                end
            end
            ST_ERS_SUSP: begin
                if (wr_stb) begin
                    if (w_data == CMD_CONFIRM) begin
                        ctl_d.state = ST_ERS_BUSY;
                        ctl_d.rmode = RM_STATUS;
                    end else if (w_data == CMD_READ_ARRAY) begin
                        ctl_d.rmode = RM_ARRAY;
                    end else if (w_data == CMD_READ_STATUS) begin
                        ctl_d.rmode = RM_STATUS;
                    end
                end
            end
            ST_PGM_SETUP: begin
                if (wr_stb) begin
                    ctl_d.rmode = RM_STATUS;
                    if (w_vpp) begin
                        pgm_we      = 1'b1;
                        op_start    = 1'b1;
                        ctl_d.state = ST_PGM_BUSY;
                        ctl_d.timer = TMR_LOAD;
                    end else begin
                        ctl_d.err.pgm = 1'b1;
                        ctl_d.err.vpp = 1'b1;
                        ctl_d.state   = ST_IDLE;
                    end
                end
            end
            ST_ERS_SETUP: begin
                if (wr_stb) begin
                    ctl_d.rmode = RM_STATUS;
                    ctl_d.state = ST_IDLE;
                    if (w_data != CMD_CONFIRM) begin
                        ctl_d.err.ers = 1'b1;
                        ctl_d.err.pgm = 1'b1;
                    end else if (!w_vpp) begin
                        ctl_d.err.ers = 1'b1;
                        ctl_d.err.vpp = 1'b1;
                    end else begin
                        ers_we      = 1'b1;
                        op_start    = 1'b1;
                        ctl_d.state = ST_ERS_BUSY;
                        ctl_d.timer = TMR_LOAD;
                    end
                end
            end
            default: begin
                if (wr_stb) begin
                    if (w_data == CMD_READ_ARRAY) begin
                        ctl_d.rmode = RM_ARRAY;
                    end else if (w_data == CMD_READ_STATUS) begin
                        ctl_d.rmode = RM_STATUS;
                    end else if (w_data == CMD_CLEAR_STATUS) begin
                        ctl_d.err = '0;
                        clr_stb   = 1'b1;
                    end else if (w_data == CMD_READ_ID) begin
                        ctl_d.rmode = RM_ID;
                    end else if ((w_data == CMD_PGM_SETUP) || (w_data == CMD_PGM_SETUP2)) begin
                        ctl_d.state = ST_PGM_SETUP;
                        ctl_d.rmode = RM_STATUS;
                    end else if (w_data == CMD_ERS_SETUP) begin
                        ctl_d.state = ST_ERS_SETUP;
                        ctl_d.rmode = RM_STATUS;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rp_n) begin
        if (!rp_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.state == ST_PGM_BUSY) || (ctl_q.state == ST_ERS_BUSY);
    assign rmode  = ctl_q.rmode;
    assign status = pack_status(!busy, ctl_q.state == ST_ERS_SUSP, ctl_q.err);

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
    import fcmd_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         BLK_W       = 2,
    parameter int         BUSY_CYC    = 64,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MFR_ID      = 8'hA7,
    parameter logic [7:0] DEV_ID      = 8'h5E
) (
    input  logic              clk,
    input  logic              rp_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              vpp_ok,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);

    logic              wr_stb;
    logic [ADDR_W-1:0] w_addr;
    logic [7:0]        w_data;
    logic              w_vpp;
    logic              rd_act;
    logic [ADDR_W-1:0] cur_addr;

    logic              pgm_we;
    logic [ADDR_W-1:0] pgm_addr;
    logic [7:0]        pgm_data;
    logic              ers_we;
    logic [BLK_W-1:0]  ers_blk;
    rmode_e            rmode;
    logic [7:0]        sts;
    logic              op_start;
    logic              clr_stb;
    logic [7:0]        arr_rd;
    logic              stat_mode;

    logic [7:0] hold_d, hold_q;

    fcmd_bus_sync #(.ADDR_W(ADDR_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(dq_in), .vpp_ok(vpp_ok),
        .wr_stb(wr_stb), .w_addr(w_addr), .w_data(w_data), .w_vpp(w_vpp),
        .rd_act(rd_act), .cur_addr(cur_addr)
    );

    fcmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYC(BUSY_CYC)) i_ctrl (
        .clk(clk), .rp_n(rp_n), .wr_stb(wr_stb), .w_addr(w_addr), .w_data(w_data),
        .w_vpp(w_vpp), .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_we(ers_we), .ers_blk(ers_blk), .rmode(rmode), .status(sts),
        .op_start(op_start), .clr_stb(clr_stb)
    );

    fcmd_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) i_array (
        .clk(clk), .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_we(ers_we), .ers_blk(ers_blk), .rd_addr(cur_addr), .rd_data(arr_rd)
    );

    // status snapshot follows the live value only while no read is open
    always_comb begin
        hold_d = rd_act ? hold_q : sts;
    end

    always_ff @(posedge clk or negedge rp_n) begin
        if (!rp_n) begin
            hold_q <= 8'h80;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign stat_mode = (rmode == RM_STATUS);
    assign dq_oe     = rd_act;

    always_comb begin
        if (stat_mode) begin
            dq_out = hold_q;
        end else if (rmode == RM_ID) begin
            dq_out = cur_addr[0] ? DEV_ID : MFR_ID;
        end else begin
            dq_out = arr_rd;
        end
    end

endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker #(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_CYC    = 64
) (
    input logic       clk,
    input logic       rp_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       dq_oe,
    input logic [7:0] dq_out,
    input logic [7:0] sts,
    input logic       clr_stb,
    input logic       op_start,
    input logic       stat_mode
);

    int unsigned busy_cnt;

    always_ff @(posedge clk or negedge rp_n) begin
        if (!rp_n) begin
            busy_cnt <= 0;
        end else if (op_start) begin
            busy_cnt <= 0;
        end else if (!sts[7]) begin
            busy_cnt <= busy_cnt + 1;
        end
    end

    AST_DRIVE_GATE: assert property (@(posedge clk) disable iff (!rp_n)
        dq_oe == $past(!ce_n && !oe_n && we_n, SYNC_STAGES)); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rp_n)
        (|($past(sts[5:3]) & ~sts[5:3])) |-> $past(clr_stb)); // R7

    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rp_n)
        (dq_oe && $past(dq_oe) && stat_mode && $past(stat_mode)) |-> $stable(dq_out)); // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rp_n)
        ($rose(sts[7]) && !sts[6]) |-> (busy_cnt == BUSY_CYC)); // R9

    AST_SUSPEND_READY: assert property (@(posedge clk) disable iff (!rp_n)
        sts[6] |-> sts[7]); // R11

endmodule

bind flash_cmd_if fcmd_checker #(.SYNC_STAGES(SYNC_STAGES), .BUSY_CYC(BUSY_CYC)) i_chk (
    .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .dq_oe(dq_oe), .dq_out(dq_out), .sts(sts), .clr_stb(clr_stb),
    .op_start(op_start), .stat_mode(stat_mode)
);

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;

    logic       clk = 1'b0;
    logic       rp_n = 1'b0;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       vpp_ok = 1'b1;
    logic [7:0] dq_in = 8'h00;
    logic [7:0] dq_out;
    logic       dq_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    event       smp_ev;

    always #5 clk = ~clk;

    flash_cmd_if #(
        .ADDR_W(8), .BLK_W(2), .BUSY_CYC(64), .SYNC_STAGES(2),
        .MFR_ID(8'hA7), .DEV_ID(8'h5E)
    ) i_flash_cmd_if (
        .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .vpp_ok(vpp_ok), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // monitor: pops an expected byte per sample request and compares
    initial begin
        forever begin
            logic [7:0] e;
            string      t;
            @(smp_ev);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (dq_oe !== 1'b1 || dq_out !== e) begin
                n_fail++;
                $display("FAIL %s: actual dq=%02h oe=%b, expected dq=%02h oe=1", t, dq_out, dq_oe, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d,
                             input bit ce_first, input bit oe_low);
        @(negedge clk);
        addr  = a;
        dq_in = d;
        oe_n  = oe_low ? 1'b0 : 1'b1;
        ce_n  = 1'b0;
        we_n  = 1'b0;
        idle(3);
        addr  = a ^ 8'h01;
        dq_in = ~d;
        if (ce_first) ce_n = 1'b1;
        else          we_n = 1'b1;
        idle(2);
        ce_n = 1'b1;
        we_n = 1'b1;
        oe_n = 1'b1;
        idle(3);
    endtask

    task automatic cmd(input logic [7:0] d);
        bus_write(8'h00, d, 1'b0, 1'b0);
    endtask

    task automatic rd_open(input logic [7:0] a);
        @(negedge clk);
        addr = a;
        we_n = 1'b1;
        ce_n = 1'b0;
        oe_n = 1'b0;
        idle(4);
    endtask

    task automatic rd_sample(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        ->smp_ev;
        #1;
    endtask

    task automatic rd_close();
        ce_n = 1'b1;
        oe_n = 1'b1;
        idle(3);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        rd_open(a);
        rd_sample(e, t);
        rd_close();
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        n_tests++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: actual %b, expected %b", t, act, e);
        end
    endtask

    initial begin
        idle(4);
        chk_bit(dq_oe, 1'b0, "R12 no drive in reset");
        rp_n = 1'b1;
        idle(3);

        cmd(8'h70);
        rd(8'h00, 8'h80, "R12 status after reset");

        // R8: erase blocks 0 and 1
        cmd(8'h20); bus_write(8'h00, 8'hD0, 1'b0, 1'b0); idle(80);
        rd(8'h00, 8'h80, "R8 erase blk0 ok");
        cmd(8'h20); bus_write(8'h40, 8'hD0, 1'b1, 1'b0); idle(80);
        cmd(8'hFF);
        rd(8'h05, 8'hFF, "R8 erased byte");

        // R1/R2/R4: program, WE rises first, data altered afterwards
        cmd(8'h40); bus_write(8'h05, 8'hF0, 1'b0, 1'b0);
        rd(8'h00, 8'h00, "R4 auto status busy");
        idle(80);
        rd(8'h00, 8'h80, "R9 ready after op");
        cmd(8'hFF);
        rd(8'h05, 8'hF0, "R1 WE-first capture");
        rd(8'h04, 8'hFF, "R1 WE-first address");

        // R1/R2: CE rises first
        cmd(8'h40); bus_write(8'h05, 8'h3C, 1'b1, 1'b0); idle(80);
        cmd(8'hFF);
        rd(8'h05, 8'h30, "R2 AND-only program (CE-first R1)");
        rd(8'h04, 8'hFF, "R1 CE-first address");

        // R3: data byte without setup is not programmed
        bus_write(8'h06, 8'h00, 1'b0, 1'b0);
        rd(8'h06, 8'hFF, "R3 no setup no program");

        // R3: program voltage low
        vpp_ok = 1'b0;
        cmd(8'h40); bus_write(8'h06, 8'h00, 1'b0, 1'b0);
        rd(8'h00, 8'h98, "R3 voltage error bits");
        cmd(8'hFF);
        rd(8'h06, 8'hFF, "R3 array unchanged");
        vpp_ok = 1'b1;

        // R7: errors survive a good program, clear on 50h
        cmd(8'h40); bus_write(8'h06, 8'h7F, 1'b0, 1'b0); idle(80);
        rd(8'h00, 8'h98, "R7 errors sticky");
        cmd(8'h50); cmd(8'h70);
        rd(8'h00, 8'h80, "R7 cleared by 50h");
        cmd(8'hFF);
        rd(8'h06, 8'h7F, "R2 program after clear");

        // R8: bad confirm
        cmd(8'h20); bus_write(8'h40, 8'hFF, 1'b0, 1'b0);
        rd(8'h00, 8'hB0, "R8 bad confirm bits");
        cmd(8'h50);

        // R8: block select keeps other blocks
        cmd(8'h40); bus_write(8'h41, 8'h12, 1'b0, 1'b0); idle(80);
        cmd(8'h20); bus_write(8'h00, 8'hD0, 1'b0, 1'b0); idle(80);
        cmd(8'hFF);
        rd(8'h41, 8'h12, "R8 other block kept");
        rd(8'h05, 8'hFF, "R8 target block filled");

        // R5: frozen status across completion
        cmd(8'h40); bus_write(8'h07, 8'h55, 1'b0, 1'b0);
        rd_open(8'h00);
        idle(80);
        rd_sample(8'h00, "R5 held during read");
        oe_n = 1'b1;
        idle(3);
        oe_n = 1'b0;
        idle(4);
        rd_sample(8'h80, "R5 refreshed after toggle");
        rd_close();

        // R1: strobe with output enable low ignored
        cmd(8'hFF);
        bus_write(8'h00, 8'h70, 1'b0, 1'b1);
        rd(8'h07, 8'h55, "R1 write with OE low ignored");

        // R10
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        idle(4);
        chk_bit(dq_oe, 1'b0, "R10 no drive while WE low");
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        idle(2);
        @(negedge clk); ce_n = 1'b0;
        idle(4);
        chk_bit(dq_oe, 1'b0, "R10 no drive while OE high");
        ce_n = 1'b1;
        idle(4);

        // R6: identifier
        cmd(8'h90);
        rd(8'h00, 8'hA7, "R6 manufacturer code");
        rd(8'h01, 8'h5E, "R6 device code");
        cmd(8'hFF);

        // R11: suspend / resume
        cmd(8'h20); bus_write(8'h80, 8'hD0, 1'b0, 1'b0);
        cmd(8'hB0);
        rd(8'h00, 8'hC0, "R11 suspended status");
        cmd(8'hD0);
        rd(8'h00, 8'h00, "R11 resumed busy");
        idle(80);
        rd(8'h00, 8'h80, "R11 resumed done");

        // R7/R12: reset clears errors, keeps array
        vpp_ok = 1'b0;
        cmd(8'h40); bus_write(8'h08, 8'h00, 1'b0, 1'b0);
        rd(8'h00, 8'h98, "R7 error before reset");
        vpp_ok = 1'b1;
        @(negedge clk); rp_n = 1'b0;
        idle(3);
        rp_n = 1'b1;
        idle(3);
        rd(8'h07, 8'h55, "R12 array mode and data kept");
        cmd(8'h70);
        rd(8'h00, 8'h80, "R7 cleared by reset");

        idle(5);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule